// File: doc/BRIEF.md
# Programmable Timing State Sequencer

The block walks through a table of 32 programmable 16-bit state words. The word that is active drives nine control outputs, and it stays active for a programmed number of timing ticks. A run always begins at entry 0 and moves up one index at a time. It finishes at the first entry whose stop flag is set, or at entry 31 if no earlier entry has the flag. After the run, the sequencer goes back to entry 0 and holds that entry's control bits as its idle outputs. The sequencing needs no processor action after the table has been written.

Three sources can start a run. A software request sets a start bit, which clears itself when the run completes. An external periodic start event can also start a run. In back-to-back repeat mode, a new run starts on the cycle after each end. The dwell of a state is measured either in fast ticks or in slow ticks. A fast tick is one clock cycle. A slow tick is one out of every `SLOW_DIV` reference tick pulses. A global enable resets the divider, the start bit and every output while it is low. Because each entry's control bits apply only while that entry is active, a single control line can be asserted for exactly one state, for example to autozero a comparator.

Top module: `state_sequencer`

## Requirements
- R1: A write with `tbl_we_i` high stores `tbl_wdata_i` into entry `tbl_waddr_i` on the clock edge. Each entry has this layout: bit 15 is the stop flag, bit 14 selects the fast tick (1) or the slow tick (0), bits 13:9 hold the repeat count, and bits 8:0 hold the control value. The control value appears on `ctrl_o` while that entry is active.
- R2: A run begins at entry 0, and `step_idx_o` rises by exactly one at each state change.
- R3: When an entry with the stop flag set completes, `step_idx_o` returns to 0, `busy_o` drops and `end_o` is high for exactly one cycle.
- R4: While idle, `ctrl_o` shows bits 8:0 of entry 0.
- R5: An entry with repeat count c stays active for c+1 ticks of the tick it selects. With the fast tick this is c+1 clock cycles.
- R6: A software request sets `sw_pending_o`. The bit stays set through the run and clears in the same cycle as the end pulse.
- R7: With repeat mode off, a pulse on `period_evt_i` while idle starts a run on the next edge.
- R8: With repeat mode on, a new run starts on the cycle after the end pulse without any request.
- R9: A software request or periodic event that arrives while a run is in progress is ignored.
- R10: While `enable_i` is low, `ctrl_o` is 0, `busy_o`, `end_o` and `sw_pending_o` are 0, `step_idx_o` is 0, and the slow-tick divider is cleared.
- R11: A write to the entry that is currently active does not change the outputs until that entry is entered again.
- R12: Entry 31 ends a run even when its stop flag is clear.
- R13: `busy_o` rises on the edge after a start condition and stays high until the end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Global enable; low holds the sequencer in reset |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_waddr_i | input | 5 | Table entry to write |
| tbl_wdata_i | input | 16 | State word to write |
| sw_start_i | input | 1 | Software start request (one-cycle pulse) |
| period_evt_i | input | 1 | Periodic start event pulse |
| repeat_mode_i | input | 1 | 1: restart immediately after each run |
| ref_tick_i | input | 1 | Reference tick pulse feeding the slow-tick divider |
| ctrl_o | output | 9 | Control bits of the active (or idle) entry |
| step_idx_o | output | 5 | Index of the active entry |
| busy_o | output | 1 | High while a run is in progress |
| end_o | output | 1 | One-cycle end-of-run pulse |
| sw_pending_o | output | 1 | Software start bit |

## Verification
The assertions check several properties on every cycle. The end pulse never lasts longer than one cycle, and it always coincides with an idle state at index 0. The index only holds or steps by one during a run. The repeat counter never passes the active entry's count. A disable always clears the outputs. The start bit falls only at an end pulse or on a disable. Other behaviours depend on a particular order of events, so only the bench scenarios can show them: exact dwell lengths, a deferred write to the running entry, the implicit stop at entry 31, repeat-mode restart, and start requests that are ignored while busy.

// File: rtl/seq_pkg.sv
// seq_pkg: layout of one state word, shared by the sequencer modules.
// Assumes a fixed 16-bit word with the fields placed as the localparams state.
package seq_pkg;
    localparam int unsigned ENTRY_W = 16;
    localparam int unsigned DEPTH   = 32;
    localparam int unsigned IDX_W   = $clog2(DEPTH);
    localparam int unsigned RPT_W   = 5;
    localparam int unsigned CTRL_W  = 9;

    typedef struct packed {
        logic              stop;
        logic              fast;
        logic [RPT_W-1:0]  rpt;
        logic [CTRL_W-1:0] ctrl;
    } seq_entry_t;
endpackage

// File: rtl/seq_table.sv
// seq_table: state-word storage with one synchronous write port and one
// combinational read port. Assumes a read in the same cycle as a write to
// the same entry returns the old word.
module seq_table #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned W     = 16,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Store words; clear the table on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read the addressed word.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/seq_tick_gen.sv
// seq_tick_gen: produces the dwell tick for the active entry. The fast tick
// fires every clock cycle. The slow tick fires on every DIV-th reference
// pulse. The divider is held cleared while the block is disabled.
module seq_tick_gen #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ref_tick,
    input  logic fast_sel,
    output logic tick
);
    logic slow_tick;

    generate
        if (DIV <= 1) begin : g_nodiv
            // No division: every reference pulse is a slow tick.
            always_comb slow_tick = ref_tick & enable;
        end else begin : g_div
            localparam int unsigned CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] div_q;

            // Count reference pulses and wrap at DIV.
            always_ff @(posedge clk) begin
                if (!rst_n || !enable) div_q <= '0;
                else if (ref_tick)     div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
            end

            // Slow tick on the last count of each divider period.
            always_comb slow_tick = ref_tick & enable & (div_q == LAST);

            assert_div_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
                div_q <= LAST);
            assert_div_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !enable |=> div_q == '0);
        end
    endgenerate

    // Pick the tick selected by the active entry.
    always_comb tick = fast_sel ? enable : slow_tick;
endmodule

// File: rtl/seq_core.sv
// seq_core: run control of the sequencer. It starts runs, counts ticks for
// each state, steps the index, latches the active word and ends runs.
// Assumes table reads are combinational and that tick is valid in the cycle
// it is used.
module seq_core
    import seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sw_start,
    input  logic             period_evt,
    input  logic             repeat_mode,
    input  logic             tick,
    input  logic [ENTRY_W-1:0] rd_word,
    output logic [IDX_W-1:0] rd_addr,
    output logic             fast_sel,
    output logic [CTRL_W-1:0] ctrl,
    output logic [IDX_W-1:0] idx,
    output logic             busy,
    output logic             eos,
    output logic             sw_pending
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    seq_entry_t       cur_q;
    logic [IDX_W-1:0] idx_q;
    logic [RPT_W-1:0] cnt_q;
    logic             run_q, eos_q, pend_q;
    logic             state_done, run_end, trigger;

    // Decode the end of a state and the end of a run.
    always_comb begin
        state_done = run_q && tick && (cnt_q == cur_q.rpt);
        run_end    = state_done && (cur_q.stop || idx_q == LAST_IDX);
        trigger    = !run_q && (sw_start || pend_q || repeat_mode || period_evt);
    end

    // Fetch the next entry when stepping, otherwise fetch entry 0.
    always_comb rd_addr = (state_done && !run_end) ? idx_q + 1'b1 : '0;

    // Sequencer state update.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cur_q  <= '0;
            idx_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            eos_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            eos_q <= 1'b0;
            if (!run_q) begin
                cur_q <= seq_entry_t'(rd_word);
                if (sw_start) pend_q <= 1'b1;
                if (trigger) begin
                    run_q <= 1'b1;
                    idx_q <= '0;
                    cnt_q <= '0;
                end
            end else if (run_end) begin
                run_q  <= 1'b0;
                idx_q  <= '0;
                cnt_q  <= '0;
                eos_q  <= 1'b1;
                pend_q <= 1'b0;
                cur_q  <= seq_entry_t'(rd_word);
            end else if (state_done) begin
                idx_q <= idx_q + 1'b1;
                cnt_q <= '0;
                cur_q <= seq_entry_t'(rd_word);
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Drive the outputs from the registered state.
    always_comb begin
        fast_sel   = cur_q.fast;
        ctrl       = cur_q.ctrl;
        idx        = idx_q;
        busy       = run_q;
        eos        = eos_q;
        sw_pending = pend_q;
    end

    assert_end_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eos_q |=> !eos_q);
    assert_end_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eos_q |-> (!run_q && idx_q == '0));
    assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q)) |-> (idx_q == $past(idx_q) || idx_q == $past(idx_q) + 1'b1));
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> cnt_q <= cur_q.rpt);
    assert_pend_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_q) |-> (eos_q || !$past(enable)));
    assert_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cur_q == '0 && !run_q && !pend_q && !eos_q));
endmodule

// File: rtl/state_sequencer.sv
// state_sequencer: top of the programmable timing state sequencer. It joins
// the word table, the tick generator and the run control.
// Assumes a single clock and a synchronous active-low reset.
module state_sequencer
    import seq_pkg::*;
#(
    parameter int unsigned SLOW_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              tbl_we_i,
    input  logic [IDX_W-1:0]  tbl_waddr_i,
    input  logic [ENTRY_W-1:0] tbl_wdata_i,
    input  logic              sw_start_i,
    input  logic              period_evt_i,
    input  logic              repeat_mode_i,
    input  logic              ref_tick_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [IDX_W-1:0]  step_idx_o,
    output logic              busy_o,
    output logic              end_o,
    output logic              sw_pending_o
);
    logic [IDX_W-1:0]   rd_addr;
    logic [ENTRY_W-1:0] rd_word;
    logic               fast_sel, tick;

    seq_table #(.DEPTH(DEPTH), .W(ENTRY_W)) u_table (
        .clk(clk), .rst_n(rst_n), .we(tbl_we_i), .waddr(tbl_waddr_i),
        .wdata(tbl_wdata_i), .raddr(rd_addr), .rdata(rd_word)
    );

    seq_tick_gen #(.DIV(SLOW_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .enable(enable_i), .ref_tick(ref_tick_i),
        .fast_sel(fast_sel), .tick(tick)
    );

    seq_core u_core (
        .clk(clk), .rst_n(rst_n), .enable(enable_i), .sw_start(sw_start_i),
        .period_evt(period_evt_i), .repeat_mode(repeat_mode_i), .tick(tick),
        .rd_word(rd_word), .rd_addr(rd_addr), .fast_sel(fast_sel),
        .ctrl(ctrl_o), .idx(step_idx_o), .busy(busy_o), .eos(end_o),
        .sw_pending(sw_pending_o)
    );
endmodule

// File: tb/sim_state_sequencer.sv
module sim_state_sequencer;
    localparam int DIV = 4;

    logic clk = 0, rst_n = 0, en = 0, we = 0, sw = 0, evt = 0, rep = 0, rtick = 0;
    logic [4:0]  waddr = 0;
    logic [15:0] wdata = 0;
    logic [8:0]  ctrl;
    logic [4:0]  idx;
    logic        busy, eos, pend;

    int n_tests = 0, n_fail = 0, cyc = 0;

    state_sequencer #(.SLOW_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .enable_i(en), .tbl_we_i(we), .tbl_waddr_i(waddr),
        .tbl_wdata_i(wdata), .sw_start_i(sw), .period_evt_i(evt), .repeat_mode_i(rep),
        .ref_tick_i(rtick), .ctrl_o(ctrl), .step_idx_o(idx), .busy_o(busy),
        .end_o(eos), .sw_pending_o(pend)
    );

    always #10 clk = ~clk;

    // Reference model state.
    logic [15:0] mtab [32];
    logic [15:0] m_cur;
    int m_idx, m_cnt, m_div;
    bit m_run, m_eos, m_sb;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        bit slow, tk, go;
        cyc++;
        if (!rst_n || !en) begin
            m_cur = 0; m_idx = 0; m_cnt = 0; m_run = 0; m_eos = 0; m_sb = 0; m_div = 0;
        end else begin
            slow = rtick && (m_div == DIV - 1);
            if (rtick) m_div = (m_div == DIV - 1) ? 0 : m_div + 1;
            tk = m_cur[14] ? 1'b1 : slow;
            m_eos = 0;
            if (!m_run) begin
                go = sw || m_sb || rep || evt;
                if (sw) m_sb = 1;
                m_cur = mtab[0];
                if (go) begin m_run = 1; m_idx = 0; m_cnt = 0; end
            end else if (tk) begin
                if (m_cnt == int'(m_cur[13:9])) begin
                    if (m_cur[15] || m_idx == 31) begin
                        m_run = 0; m_idx = 0; m_cnt = 0; m_eos = 1; m_sb = 0; m_cur = mtab[0];
                    end else begin
                        m_idx++; m_cur = mtab[m_idx]; m_cnt = 0;
                    end
                end else m_cnt++;
            end
        end
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) mtab[i] = 0;
        end else if (we) mtab[waddr] = wdata;
    end

    // Compare every cycle against the model, away from the active edge.
    always @(negedge clk) if (rst_n) begin
        chk("R4/R1 ctrl", ctrl, m_cur[8:0]);
        chk("R2 index", idx, m_idx);
        chk("R13 busy", busy, m_run);
        chk("R3 end pulse", eos, m_eos);
        chk("R6 start bit", pend, m_sb);
    end

    // Reference pulse on every third cycle.
    int rph = 0;
    always @(negedge clk) begin
        rph = (rph == 2) ? 0 : rph + 1;
        rtick <= (rph == 0);
    end

    // Watchdog.
    initial begin
        #(20 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic nclk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        we = 1; waddr = 5'(a); wdata = d; @(negedge clk); we = 0;
    endtask

    task automatic pulse_sw(); sw = 1; @(negedge clk); sw = 0; endtask

    task automatic wait_end(input string req);
        int k = 0;
        while (!eos && k < 2000) begin @(negedge clk); k++; end
        chk({req, " end reached"}, eos, 1);
    endtask

    task automatic wait_idx(input int v);
        int k = 0;
        while (!(busy && idx == 5'(v)) && k < 2000) begin @(negedge clk); k++; end
    endtask

    initial begin
        int len, mx;
        nclk(2);
        rst_n = 1;
        @(negedge clk);
        chk("R10 reset ctrl", ctrl, 0);
        chk("R10 reset busy", busy, 0);
        en = 1;
        // entry word: stop, fast, rpt[4:0], ctrl[8:0]
        wr(0, {1'b0, 1'b1, 5'd1, 9'h001});
        wr(1, {1'b0, 1'b1, 5'd2, 9'h0A2});
        wr(2, {1'b0, 1'b0, 5'd1, 9'h104});
        wr(3, {1'b1, 1'b1, 5'd0, 9'h008});
        nclk(1);
        chk("R4 idle shows entry 0", ctrl, 9'h001);

        // Software start, dwell of entry 1, ignored requests while busy.
        pulse_sw();
        chk("R6 start bit set", pend, 1);
        chk("R13 busy after start", busy, 1);
        wait_idx(1);
        chk("R1 entry 1 control", ctrl, 9'h0A2);
        len = 0;
        while (busy && idx == 1) begin len++; @(negedge clk); end
        chk("R5 fast dwell count+1", len, 3);
        evt = 1; pulse_sw(); evt = 0;
        chk("R9 busy unaffected", busy, 1);
        wait_end("R3");
        chk("R3 index back to 0", idx, 0);
        chk("R6 start bit cleared", pend, 0);
        nclk(1);
        chk("R3 end lasts one cycle", eos, 0);
        chk("R9 no queued restart", busy, 0);
        chk("R4 idle after end", ctrl, 9'h001);

        // Periodic event start.
        evt = 1; @(negedge clk); evt = 0;
        chk("R7 event starts run", busy, 1);
        chk("R7 event leaves start bit", pend, 0);
        wait_idx(1);
        wr(1, {1'b0, 1'b1, 5'd2, 9'h055});
        chk("R11 running entry unchanged", ctrl, 9'h0A2);
        wait_end("R7");
        nclk(2);
        pulse_sw();
        wait_idx(1);
        chk("R11 new word on re-entry", ctrl, 9'h055);
        wait_end("R11");

        // Repeat mode.
        rep = 1;
        nclk(1);
        wait_end("R8");
        chk("R8 idle in end cycle", busy, 0);
        nclk(1);
        chk("R8 immediate restart", busy, 1);
        rep = 0;
        wait_end("R8 last");
        nclk(2);

        // Implicit stop at entry 31.
        for (int i = 0; i < 32; i++) wr(i, {1'b0, 1'b1, 5'd0, 9'(i)});
        pulse_sw();
        mx = 0;
        while (!eos) begin if (int'(idx) > mx) mx = idx; @(negedge clk); end
        chk("R12 last index reached", mx, 31);
        chk("R12 end after entry 31", eos, 1);
        nclk(2);

        // Disable in the middle of a run.
        wr(0, {1'b0, 1'b1, 5'd3, 9'h1F0});
        pulse_sw();
        nclk(2);
        en = 0;
        @(negedge clk);
        chk("R10 disabled ctrl", ctrl, 0);
        chk("R10 disabled busy", busy, 0);
        chk("R10 disabled index", idx, 0);
        nclk(3);
        en = 1;
        nclk(2);
        chk("R4 idle after enable", ctrl, 9'h1F0);
        nclk(20);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule